// File: doc/BRIEF.md
# Neighbour Job Load Balancer Node

This block is one node of a mesh of processing cores. It holds a small last-in, first-out stack of job descriptors that the attached core fills and drains through local push and pop ports. Each cycle the node looks at the job counts reported by its four nearest neighbours. If the least loaded neighbour holds strictly fewer jobs than the node itself, the node raises a transfer request towards that neighbour.

A neighbour that answers with a grant in the same cycle receives the job on top of the requester's stack, and the requester drops it at that clock edge. A whole transfer therefore takes one cycle. Each node also serves incoming requests from its neighbours. A round-robin arbiter picks at most one of them per cycle, and the chosen neighbour's job word is written onto the local stack.

The node publishes its own job count on a registered output, which feeds the count inputs of its neighbours. At a mesh edge the missing neighbour's count input is tied to all ones, so that port is never chosen.

Top module: `job_balance_node`

## Requirements
- R1: While reset is asserted and after it is released, the job count is 0, and no request, grant, pop valid or push accept is issued until stimulus arrives.
- R2: The stack is last-in, first-out. A push is accepted (push_accept high) when the stack has room for it after the other writes and removals of the cycle. pop_valid is high when pop_req is high, the stack is not empty and no transfer is being sent. pop_job is then the most recently stored job, which is removed at the clock edge.
- R3: The neighbour count fields are packed so that port i (0 north, 1 east, 2 south, 3 west) sits at bits [i*CNT_W +: CNT_W]. The node requests on the port with the smallest count, and the lowest port index wins a tie. A request is raised only when that count is strictly less than the node's own count.
- R4: A node with an empty stack never requests. A port whose count reads all ones, which marks an absent neighbour, is never requested.
- R5: When the requested port's grant_in is high in the same cycle, the node sends: job_out carries the top job, that job leaves the stack at the clock edge, and at most one request bit is high.
- R6: Incoming requests are served by a round-robin arbiter. At most one grant_out bit is high. The search starts at the port after the last one granted, and port 0 is searched first after reset.
- R7: No grant is issued while the node is raising any request of its own or while its stack is full.
- R8: A granted neighbour's job word (job_in bits [i*JOB_W +: JOB_W]) is written onto the stack. A push accepted in the same cycle is stored above it, so the pushed job is the next one popped.
- R9: my_count is a register. It shows the stack occupancy that results from all the push, pop, send and receive activity of the previous cycle.
- R10: A core pop is refused (pop_valid low) in any cycle in which the node sends a job to a neighbour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Balancer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Core offers a job |
| push_job | input | JOB_W | Job word offered by the core |
| push_accept | output | 1 | Offered job is stored at this edge |
| pop_req | input | 1 | Core asks for a job |
| pop_valid | output | 1 | pop_job is valid and removed at this edge |
| pop_job | output | JOB_W | Top-of-stack job for the core |
| my_count | output | CNT_W | Registered job count of this node |
| nbr_count | input | 4*CNT_W | Neighbour job counts, all ones when absent |
| req_out | output | 4 | Transfer request towards one neighbour |
| grant_in | input | 4 | Grants returned by neighbours |
| job_out | output | JOB_W | Job word sent on a granted request |
| req_in | input | 4 | Transfer requests from neighbours |
| grant_out | output | 4 | Grant to one requesting neighbour |
| job_in | input | 4*JOB_W | Job words from the neighbours |

## Verification
The in-module assertions check the invariants on every cycle. They cover the one-hot request and grant vectors, the rule that a request only ever targets a neighbour with fewer jobs, the refusal to grant while full or while requesting, the refusal of a core pop while sending, the count bound, and the one-job decrement after a send. The bench scenarios are needed for the behaviour that depends on order and history: which job comes back out of the stack, tie-breaking between equal neighbours, the rotation of the round-robin pointer, and the combined effect of a receive, a push and a pop in the same cycle on the registered count.

// File: rtl/job_balance_node.sv
`timescale 1ns/1ps
module job_balance_node #(
  parameter int DEPTH = 8,
  parameter int JOB_W = 16,
  localparam int NPORT = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int AW    = $clog2(DEPTH),
  localparam int PW    = $clog2(NPORT)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_valid,
  input  logic [JOB_W-1:0]       push_job,
  output logic                   push_accept,
  input  logic                   pop_req,
  output logic                   pop_valid,
  output logic [JOB_W-1:0]       pop_job,
  output logic [CNT_W-1:0]       my_count,
  input  logic [NPORT*CNT_W-1:0] nbr_count,
  output logic [NPORT-1:0]       req_out,
  input  logic [NPORT-1:0]       grant_in,
  output logic [JOB_W-1:0]       job_out,
  input  logic [NPORT-1:0]       req_in,
  output logic [NPORT-1:0]       grant_out,
  input  logic [NPORT*JOB_W-1:0] job_in
);

  logic [CNT_W-1:0] cnt;
  logic [JOB_W-1:0] stack [DEPTH];
  logic [PW-1:0]    last_gnt;

  logic [CNT_W-1:0] best_cnt;
  logic [PW-1:0]    best_idx;
  logic [PW-1:0]    gnt_idx;
  logic             gnt_any;
  logic             send, recv, can_grant;
  logic [JOB_W-1:0] top_job, rx_job;
  int               base, fill;

  // least-loaded neighbour, lowest index on a tie
  always_comb begin
    best_cnt = nbr_count[CNT_W-1:0];
    best_idx = '0;
    for (int i = 1; i < NPORT; i++)
      if (nbr_count[i*CNT_W +: CNT_W] < best_cnt) begin
        best_cnt = nbr_count[i*CNT_W +: CNT_W];
        best_idx = PW'(i);
      end
  end

  assign req_out = (best_cnt < cnt) ? (NPORT'(1) << best_idx) : '0;
  assign send    = |(req_out & grant_in);

  // round-robin over incoming requests
  assign can_grant = (req_out == '0) && (int'(cnt) < DEPTH);

  always_comb begin
    gnt_any = 1'b0;
    gnt_idx = '0;
    for (int k = 1; k <= NPORT; k++) begin
      int p;
      p = (int'(last_gnt) + k) % NPORT;
      if (!gnt_any && req_in[p]) begin
        gnt_any = 1'b1;
        gnt_idx = PW'(p);
      end
    end
  end

  assign grant_out = (can_grant && gnt_any) ? (NPORT'(1) << gnt_idx) : '0;
  assign recv      = |grant_out;
  assign rx_job    = job_in[int'(gnt_idx)*JOB_W +: JOB_W];

  assign top_job   = (cnt != '0) ? stack[AW'(int'(cnt) - 1)] : '0;
  assign job_out   = top_job;
  assign pop_job   = top_job;
  assign pop_valid = pop_req && (cnt != '0) && !send;

  assign base        = int'(cnt) - int'(pop_valid) - int'(send);
  assign fill        = base + int'(recv);
  assign push_accept = push_valid && (fill < DEPTH);

  always_ff @(posedge clk) begin
    if (recv)        stack[AW'(base)] <= rx_job;
    if (push_accept) stack[AW'(fill)] <= push_job;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      last_gnt <= PW'(NPORT - 1);
    end else begin
      cnt <= CNT_W'(fill + int'(push_accept));
      if (recv) last_gnt <= gnt_idx;
    end
  end

  assign my_count = cnt;

  a_r5_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_out));
  a_r6_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_out));
  a_r4_no_req_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (my_count == '0) |-> (req_out == '0));
  a_r7_no_grant_full: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(my_count) >= DEPTH) |-> (grant_out == '0));
  a_r7_no_grant_while_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_out != '0) |-> (grant_out == '0));
  a_r10_no_pop_on_send: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_out & grant_in)) |-> !pop_valid);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    int'(my_count) <= DEPTH);
  a_r5_send_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(req_out & grant_in)) && !push_accept) |=> (my_count == $past(my_count) - 1'b1));
  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_chk
      a_r3_req_smaller: assert property (@(posedge clk) disable iff (!rst_n)
        req_out[g] |-> (nbr_count[g*CNT_W +: CNT_W] < my_count));
      a_r6_grant_requested: assert property (@(posedge clk) disable iff (!rst_n)
        grant_out[g] |-> req_in[g]);
    end
  endgenerate

endmodule

// File: tb/test_job_balance_node.sv
`timescale 1ns/1ps
module test_job_balance_node;
  localparam int DEPTH = 8;
  localparam int JOB_W = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int NP = 4;
  localparam logic [CNT_W-1:0] ABSENT = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic push_valid = 1'b0, pop_req = 1'b0, push_accept, pop_valid;
  logic [JOB_W-1:0] push_job = '0, pop_job, job_out;
  logic [CNT_W-1:0] my_count;
  logic [NP*CNT_W-1:0] nbr_count = '1;
  logic [NP-1:0] req_out, grant_in = '0, req_in = '0, grant_out;
  logic [NP*JOB_W-1:0] job_in = '0;

  job_balance_node #(.DEPTH(DEPTH), .JOB_W(JOB_W)) i_job_balance_node (
    .clk, .rst_n, .push_valid, .push_job, .push_accept, .pop_req, .pop_valid,
    .pop_job, .my_count, .nbr_count, .req_out, .grant_in, .job_out,
    .req_in, .grant_out, .job_in);

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [JOB_W-1:0] m_stack [DEPTH];
  int m_cnt = 0;
  int m_last = NP - 1;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [NP-1:0] exp_req(logic [NP*CNT_W-1:0] nc, int c);
    int bi = 0;
    for (int i = 1; i < NP; i++)
      if (nc[i*CNT_W +: CNT_W] < nc[bi*CNT_W +: CNT_W]) bi = i;
    if (int'(nc[bi*CNT_W +: CNT_W]) < c) return NP'(1) << bi;
    return '0;
  endfunction

  function automatic int exp_gnt(logic [NP-1:0] rin, int last);
    for (int k = 1; k <= NP; k++)
      if (rin[(last + k) % NP]) return (last + k) % NP;
    return -1;
  endfunction

  // one cycle: drive at the falling edge, check the combinational outputs,
  // update the model, then check the registered count after the edge
  task automatic step(logic [NP*CNT_W-1:0] nc, logic [NP-1:0] rin, logic [NP-1:0] gin,
                      logic pv, logic [JOB_W-1:0] pj, logic pr, logic [NP*JOB_W-1:0] jin);
    logic [NP-1:0] er, eg;
    int gi, base;
    logic snd, rcv, epv, epa;
    nbr_count = nc; req_in = rin; grant_in = gin;
    push_valid = pv; push_job = pj; pop_req = pr; job_in = jin;
    #1;
    er  = exp_req(nc, m_cnt);
    snd = |(er & gin);
    gi  = (er == '0 && m_cnt < DEPTH) ? exp_gnt(rin, m_last) : -1;
    eg  = (gi >= 0) ? (NP'(1) << gi) : '0;
    rcv = (gi >= 0);
    epv = pr && m_cnt > 0 && !snd;
    base = m_cnt - int'(epv) - int'(snd);
    epa = pv && (base + int'(rcv) < DEPTH);
    chk("R3/R4 req_out", 32'(req_out), 32'(er));
    chk("R6/R7 grant_out", 32'(grant_out), 32'(eg));
    chk("R2/R10 pop_valid", 32'(pop_valid), 32'(epv));
    chk("R2/R8 push_accept", 32'(push_accept), 32'(epa));
    if (epv) chk("R2 pop_job LIFO", 32'(pop_job), 32'(m_stack[m_cnt-1]));
    if (snd) chk("R5 job_out", 32'(job_out), 32'(m_stack[m_cnt-1]));
    if (rcv) begin
      m_stack[base] = jin[gi*JOB_W +: JOB_W];
      m_last = gi;
    end
    if (epa) m_stack[base + int'(rcv)] = pj;
    m_cnt = base + int'(rcv) + int'(epa);
    @(posedge clk); @(negedge clk);
    chk("R9 my_count", 32'(my_count), 32'(m_cnt));
  endtask

  function automatic logic [NP*CNT_W-1:0] pack4(int a, int b, int c, int d);
    return {CNT_W'(d), CNT_W'(c), CNT_W'(b), CNT_W'(a)};
  endfunction

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1 count in reset", 32'(my_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 count after reset", 32'(my_count), 0);
    chk("R1 no req", 32'(req_out), 0);
    chk("R1 no grant", 32'(grant_out), 0);
    chk("R1 no pop", 32'(pop_valid), 0);
    chk("R1 no accept", 32'(push_accept), 0);
    // R4: empty node, low neighbours: no request
    step(pack4(0, 0, 0, 0), '0, '1, 0, 0, 0, '0);
    // R2: fill with known jobs, neighbours absent
    for (int i = 0; i < DEPTH + 1; i++)
      step('1, '0, '0, 1, JOB_W'(16'h100 + i), 0, '0);
    // R7: full stack refuses grant, but must request when a neighbour is lighter
    step('1, 4'b1111, '0, 0, 0, 0, '0);
    // R3 tie: ports 1 and 3 at 2, lowest wins; R5 grant sends top
    step(pack4(5, 2, 6, 2), '0, 4'b0010, 0, 0, 1, '0);
    // R3 strictness: equal count gives no request
    step(pack4(m_cnt, ABSENT, ABSENT, ABSENT), '0, '0, 0, 0, 0, '0);
    // drain to 2 jobs then R6 round robin with all requesting
    while (m_cnt > 2) step('1, '0, '0, 0, 0, 1, '0);
    for (int r = 0; r < 4; r++) begin
      step('1, 4'b1111, '0, 1, JOB_W'(16'h200 + r), 0, {16'hd3, 16'hd2, 16'hd1, 16'hd0});
      step('1, '0, '0, 0, 0, 1, '0);
      step('1, '0, '0, 0, 0, 1, '0);
    end
    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic [NP*CNT_W-1:0] nc;
      for (int p = 0; p < NP; p++)
        nc[p*CNT_W +: CNT_W] = ($urandom % 8 == 0) ? ABSENT : CNT_W'($urandom % (DEPTH + 1));
      step(nc, NP'($urandom & $urandom), NP'($urandom), ($urandom % 100) < ((n / 500) % 2 ? 30 : 70),
           JOB_W'($urandom), ($urandom % 100) < 40, {JOB_W'($urandom), JOB_W'($urandom), JOB_W'($urandom), JOB_W'($urandom)});
    end
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule